// File: doc/BRIEF.md
# DSP Control and Interrupt Register

This block holds the host-visible control word of an audio DSP subsystem. It gathers interrupt events from three sources (the audio DMA, the auxiliary memory DMA and the DSP core). Each source has a sticky status flag and an enable bit. A single level interrupt goes to the host whenever an enabled flag is pending. The same word carries the DSP reset, halt, init and assert-interrupt controls, and a read-only view of the auxiliary DMA busy state. Writing the reset control also wipes the audio DMA control register, which sits in the same small register window.

The host reaches the window through a bridge. A 16-bit access goes straight through. A 32-bit access becomes two 16-bit beats on consecutive cycles. The first beat carries the upper half at the given offset, and the second carries the lower half at offset + 2. A 32-bit read returns the first beat's data in the upper half. Software uses this to program the audio DMA control and the DSP control word in one 32-bit store, and the high-first order decides which side effect lands last.

Top module: `dspc_top`

## Requirements
- R1: After reset, both registers read 0x0000, `irq` is low and all control outputs are low.
- R2: A one-cycle pulse on `ev_audio`, `ev_aux` or `ev_dsp` sets the matching status flag: bit 3, bit 5 or bit 7 of the control word. If the pulse arrives in the same cycle as a write of 1 to that flag, the flag stays set.
- R3: Writing 1 to a status flag clears it. Writing 0 to it leaves it unchanged.
- R4: The enable bits (bit 4 audio, 6 auxiliary, 8 DSP) and the control bits (0 reset, 1 assert-interrupt, 2 halt, 11 init) take the written value. The reset, assert-interrupt, halt and init bits are driven on `dsp_reset`, `dsp_assert`, `dsp_halt` and `dsp_init`.
- R5: `irq` is high exactly when some status flag and its enable bit are both 1.
- R6: A control-word write with bit 0 set forces the audio DMA control register (offset 0) to 0x0000 at the same clock edge.
- R7: A control-word write with any of bits 10, 12, 13, 14 or 15 set raises `pad_err` for exactly the following cycle. Those bits always read 0.
- R8: A 32-bit access at offset A is carried out as a beat at A with data bits 31:16, then a beat at A+2 with bits 15:0, on the next cycle. `hst_busy` is high during the second beat. A 32-bit read returns {data at A, data at A+2}.
- R9: Control-word bit 9 reads the `aux_busy` input, and writes to bit 9 have no effect.
- R10: The audio DMA control register sits at offset 0 and the control word at offset 2. Other offsets read 0x0000 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_req | input | 1 | Host access request, one cycle, only while not busy |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| hst_addr | input | AW | Byte offset in the register window |
| hst_wdata | input | 32 | Write data (16-bit access uses bits 15:0) |
| hst_busy | output | 1 | Second beat of a 32-bit access in progress |
| hst_rvalid | output | 1 | Read data valid, one cycle after the last beat |
| hst_rdata | output | 32 | Read data |
| ev_audio | input | 1 | Audio DMA block-done event pulse |
| ev_aux | input | 1 | Auxiliary DMA done event pulse |
| ev_dsp | input | 1 | DSP core interrupt request pulse |
| aux_busy | input | 1 | Auxiliary DMA transfer in progress |
| irq | output | 1 | Combined interrupt to the host |
| dsp_reset | output | 1 | DSP reset control |
| dsp_assert | output | 1 | Assert-interrupt control to the DSP |
| dsp_halt | output | 1 | DSP halt control |
| dsp_init | output | 1 | DSP init control |
| pad_err | output | 1 | Write with nonzero padding bits seen |
| adma_ctrl | output | 16 | Audio DMA control register value |

## Verification
The flags are first raised with their enables off, to show that a pending flag alone does not reach `irq`. They are then cleared by writes that carry 0 and then 1 in the flag position, which separates a write-1-to-clear from a plain store. One write is issued in the same cycle as a matching event, which shows whether the set or the clear takes priority. A 32-bit store that loads the audio DMA register and also sets the reset bit shows the beat order: high-first leaves the audio DMA register at zero, while the reverse order would leave the stored value.

// File: rtl/dspc_pkg.sv
package dspc_pkg;
  localparam int NSRC    = 3;          // audio, aux, dsp
  localparam int B_RST   = 0;
  localparam int B_ASRT  = 1;
  localparam int B_HALT  = 2;
  localparam int B_BUSY  = 9;
  localparam int B_INIT  = 11;
  localparam logic [15:0] PAD_MASK = 16'hF400;

  typedef logic [15:0] half_t;

  function automatic int flag_pos(input int src);
    return 3 + 2 * src;
  endfunction

  function automatic int mask_pos(input int src);
    return 4 + 2 * src;
  endfunction
endpackage

// File: rtl/dspc_bridge.sv
module dspc_bridge #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hst_req,
  input  logic          hst_we,
  input  logic          hst_wide,
  input  logic [AW-1:0] hst_addr,
  input  logic [31:0]   hst_wdata,
  input  dspc_pkg::half_t rd16,
  output logic          acc_vld,
  output logic          acc_we,
  output logic [AW-1:0] acc_addr,
  output dspc_pkg::half_t acc_wdata,
  output logic          hst_busy,
  output logic          hst_rvalid,
  output logic [31:0]   hst_rdata
);
  import dspc_pkg::*;

  localparam logic [AW-1:0] HALF_STEP = AW'(2);

  logic          pend_q, pend_d;
  logic          pwe_q;
  logic [AW-1:0] paddr_q;
  half_t         pdata_q, hi_q;
  logic          rv_q, rv_d;
  logic [31:0]   rdata_q, rdata_d;
  logic          start_wide;

  // beat selection: pending low half has priority, new requests wait
  always_comb begin
    if (pend_q) begin
      acc_vld   = 1'b1;
      acc_we    = pwe_q;
      acc_addr  = paddr_q;
      acc_wdata = pdata_q;
    end else begin
      acc_vld   = hst_req;
      acc_we    = hst_we;
      acc_addr  = hst_addr;
      acc_wdata = hst_wide ? hst_wdata[31:16] : hst_wdata[15:0];
    end
  end

  always_comb begin
    start_wide = !pend_q && hst_req && hst_wide;
    pend_d     = start_wide;
    rv_d       = acc_vld && !acc_we && (pend_q || !hst_wide);
    rdata_d    = pend_q ? {hi_q, rd16} : {16'h0000, rd16};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      rv_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      rv_q   <= rv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start_wide) begin
      pwe_q   <= hst_we;
      paddr_q <= hst_addr + HALF_STEP;
      pdata_q <= hst_wdata[15:0];
      hi_q    <= rd16;
    end
    if (rv_d) begin
      rdata_q <= rdata_d;
    end
  end

  assign hst_busy   = pend_q;
  assign hst_rvalid = rv_q;
  assign hst_rdata  = rdata_q;
endmodule

// File: rtl/dspc_ctrl.sv
module dspc_ctrl (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  dspc_pkg::half_t wdata,
  input  logic [2:0]      ev_set,
  input  logic            busy_in,
  output dspc_pkg::half_t rd_view,
  output logic            irq,
  output logic            adma_clr,
  output logic            pad_err,
  output logic            rst_o,
  output logic            asrt_o,
  output logic            halt_o,
  output logic            init_o
);
  import dspc_pkg::*;

  logic [NSRC-1:0] flag_q, flag_d, mask_q, mask_d;
  logic [3:0]      cbit_q, cbit_d;   // {init, halt, asrt, rst}
  logic            perr_q, perr_d;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    always_comb begin
      flag_d[s] = (flag_q[s] && !(wr_en && wdata[flag_pos(s)])) || ev_set[s];
      mask_d[s] = wr_en ? wdata[mask_pos(s)] : mask_q[s];
    end
  end

  always_comb begin
    cbit_d   = wr_en ? {wdata[B_INIT], wdata[B_HALT], wdata[B_ASRT], wdata[B_RST]}
                     : cbit_q;
    perr_d   = wr_en && ((wdata & PAD_MASK) != 16'h0000);
    adma_clr = wr_en && wdata[B_RST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
      cbit_q <= '0;
      perr_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      mask_q <= mask_d;
      cbit_q <= cbit_d;
      perr_q <= perr_d;
    end
  end

  always_comb begin
    rd_view         = '0;
    rd_view[B_RST]  = cbit_q[0];
    rd_view[B_ASRT] = cbit_q[1];
    rd_view[B_HALT] = cbit_q[2];
    rd_view[B_INIT] = cbit_q[3];
    rd_view[B_BUSY] = busy_in;
    for (int s = 0; s < NSRC; s++) begin
      rd_view[flag_pos(s)] = flag_q[s];
      rd_view[mask_pos(s)] = mask_q[s];
    end
  end

  assign irq     = |(flag_q & mask_q);
  assign pad_err = perr_q;
  assign rst_o   = cbit_q[0];
  assign asrt_o  = cbit_q[1];
  assign halt_o  = cbit_q[2];
  assign init_o  = cbit_q[3];
endmodule

// File: rtl/dspc_adma_reg.sv
module dspc_adma_reg (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            clr,
  input  dspc_pkg::half_t wdata,
  output dspc_pkg::half_t q
);
  import dspc_pkg::*;

  half_t q_r, q_d;
  logic  en;

  always_comb begin
    en  = wr_en || clr;
    q_d = clr ? 16'h0000 : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else if (en) q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/dspc_top.sv
module dspc_top #(
  parameter int AW       = 4,
  parameter int ADMA_OFS = 0,
  parameter int CTRL_OFS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hst_req,
  input  logic          hst_we,
  input  logic          hst_wide,
  input  logic [AW-1:0] hst_addr,
  input  logic [31:0]   hst_wdata,
  output logic          hst_busy,
  output logic          hst_rvalid,
  output logic [31:0]   hst_rdata,
  input  logic          ev_audio,
  input  logic          ev_aux,
  input  logic          ev_dsp,
  input  logic          aux_busy,
  output logic          irq,
  output logic          dsp_reset,
  output logic          dsp_assert,
  output logic          dsp_halt,
  output logic          dsp_init,
  output logic          pad_err,
  output logic [15:0]   adma_ctrl
);
  import dspc_pkg::*;

  localparam logic [AW-1:0] A_ADMA = AW'(ADMA_OFS);
  localparam logic [AW-1:0] A_CTRL = AW'(CTRL_OFS);

  logic          acc_vld, acc_we;
  logic [AW-1:0] acc_addr;
  half_t         acc_wdata, rd16, ctrl_rd, adma_q;
  logic          ctrl_wr, adma_wr, adma_clr;

  always_comb begin
    ctrl_wr = acc_vld && acc_we && (acc_addr == A_CTRL);
    adma_wr = acc_vld && acc_we && (acc_addr == A_ADMA);
    if (acc_addr == A_CTRL)      rd16 = ctrl_rd;
    else if (acc_addr == A_ADMA) rd16 = adma_q;
    else                         rd16 = '0;
  end

  dspc_bridge #(.AW(AW)) u_bridge (
    .clk(clk), .rst_n(rst_n),
    .hst_req(hst_req), .hst_we(hst_we), .hst_wide(hst_wide),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .rd16(rd16),
    .acc_vld(acc_vld), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .hst_busy(hst_busy),
    .hst_rvalid(hst_rvalid), .hst_rdata(hst_rdata)
  );

  dspc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wdata(acc_wdata),
    .ev_set({ev_dsp, ev_aux, ev_audio}), .busy_in(aux_busy),
    .rd_view(ctrl_rd), .irq(irq), .adma_clr(adma_clr), .pad_err(pad_err),
    .rst_o(dsp_reset), .asrt_o(dsp_assert), .halt_o(dsp_halt), .init_o(dsp_init)
  );

  dspc_adma_reg u_adma (
    .clk(clk), .rst_n(rst_n), .wr_en(adma_wr), .clr(adma_clr),
    .wdata(acc_wdata), .q(adma_q)
  );

  assign adma_ctrl = adma_q;
endmodule

// File: rtl/dspc_chk.sv
module dspc_chk #(
  parameter int AW       = 4,
  parameter int CTRL_OFS = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_vld,
  input logic          acc_we,
  input logic [AW-1:0] acc_addr,
  input logic [15:0]   acc_wdata,
  input logic [15:0]   ctrl_rd,
  input logic [15:0]   adma_q,
  input logic          ev_audio,
  input logic          ev_aux,
  input logic          aux_busy,
  input logic          irq,
  input logic          pad_err,
  input logic          hst_busy
);
  logic cw;
  assign cw = acc_vld && acc_we && (acc_addr == AW'(CTRL_OFS));

  assert_set_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_audio |=> ctrl_rd[3]);

  assert_hold_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[5] && !ev_aux && !cw) |=> ctrl_rd[5]);

  assert_no_enable_no_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rd[4] && !ctrl_rd[6] && !ctrl_rd[8]) |-> !irq);

  assert_reset_wipes_adma_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && acc_wdata[0]) |=> (adma_q == 16'h0000));

  assert_pad_from_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pad_err |-> $past(cw));

  assert_one_extra_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hst_busy |=> !hst_busy);

  assert_busy_view_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[9] == aux_busy);
endmodule

bind dspc_top dspc_chk #(.AW(AW), .CTRL_OFS(CTRL_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_we(acc_we),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .ctrl_rd(ctrl_rd),
  .adma_q(adma_q), .ev_audio(ev_audio), .ev_aux(ev_aux),
  .aux_busy(aux_busy), .irq(irq), .pad_err(pad_err), .hst_busy(hst_busy)
);

// File: tb/tb_dspc_top.sv
module tb_dspc_top;
  localparam int AW = 4;
  localparam logic [AW-1:0] OA = 4'd0;   // audio DMA control
  localparam logic [AW-1:0] OC = 4'd2;   // control word

  logic clk, rst_n;
  logic hst_req, hst_we, hst_wide;
  logic [AW-1:0] hst_addr;
  logic [31:0] hst_wdata, hst_rdata;
  logic hst_busy, hst_rvalid;
  logic ev_audio, ev_aux, ev_dsp, aux_busy;
  logic irq, dsp_reset, dsp_assert, dsp_halt, dsp_init, pad_err;
  logic [15:0] adma_ctrl;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  dspc_top #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_we(hst_we),
    .hst_wide(hst_wide), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_busy(hst_busy), .hst_rvalid(hst_rvalid), .hst_rdata(hst_rdata),
    .ev_audio(ev_audio), .ev_aux(ev_aux), .ev_dsp(ev_dsp),
    .aux_busy(aux_busy), .irq(irq), .dsp_reset(dsp_reset),
    .dsp_assert(dsp_assert), .dsp_halt(dsp_halt), .dsp_init(dsp_init),
    .pad_err(pad_err), .adma_ctrl(adma_ctrl)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && hst_rvalid) begin
      if (exp_q.size() == 0) chk("R8 unexpected read", 32'h1, 32'h0);
      else chk(tag_q.pop_front(), hst_rdata, exp_q.pop_front());
    end
  end

  // all tasks are entered at a negedge and return at a negedge
  task automatic acc(input logic we, input logic wide, input logic [AW-1:0] a,
                     input logic [31:0] d);
    hst_req = 1'b1; hst_we = we; hst_wide = wide; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_req = 1'b0;
    if (wide) begin
      chk("R8 busy during second beat", {31'h0, hst_busy}, 32'h1);
      @(negedge clk);
    end
  endtask

  task automatic wr16(input logic [AW-1:0] a, input logic [15:0] d);
    acc(1'b1, 1'b0, a, {16'h0, d});
  endtask

  task automatic rd16(input logic [AW-1:0] a, input logic [15:0] e, input string tag);
    exp_q.push_back({16'h0, e}); tag_q.push_back(tag);
    acc(1'b0, 1'b0, a, 32'h0);
    @(negedge clk);
  endtask

  task automatic rd32(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    acc(1'b0, 1'b1, a, 32'h0);
    @(negedge clk);
  endtask

  task automatic pulse(input int which);
    if (which == 0) ev_audio = 1'b1;
    if (which == 1) ev_aux = 1'b1;
    if (which == 2) ev_dsp = 1'b1;
    @(negedge clk);
    ev_audio = 1'b0; ev_aux = 1'b0; ev_dsp = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; hst_req = 1'b0; hst_we = 1'b0; hst_wide = 1'b0;
    hst_addr = '0; hst_wdata = '0;
    ev_audio = 1'b0; ev_aux = 1'b0; ev_dsp = 1'b0; aux_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 controls", {28'h0, dsp_reset, dsp_assert, dsp_halt, dsp_init}, 32'h0);
    rd16(OC, 16'h0000, "R1 control word");
    rd16(OA, 16'h0000, "R1 audio dma reg");

    wr16(OA, 16'h8123);
    rd16(OA, 16'h8123, "R10 audio dma store");
    chk("R10 adma_ctrl port", {16'h0, adma_ctrl}, 32'h8123);
    wr16(4'd4, 16'hFFFF);
    rd16(4'd4, 16'h0000, "R10 unmapped offset");

    pulse(0);
    rd16(OC, 16'h0008, "R2 audio flag set");
    chk("R5 masked flag no irq", {31'h0, irq}, 32'h0);
    wr16(OC, 16'h0010);
    rd16(OC, 16'h0018, "R3 write 0 keeps flag, R4 mask stored");
    chk("R5 irq enabled", {31'h0, irq}, 32'h1);
    wr16(OC, 16'h0018);
    rd16(OC, 16'h0010, "R3 write 1 clears flag");
    chk("R5 irq after clear", {31'h0, irq}, 32'h0);

    pulse(1);
    rd16(OC, 16'h0030, "R2 aux flag set");
    ev_aux = 1'b1;
    wr16(OC, 16'h0060);
    ev_aux = 1'b0;
    rd16(OC, 16'h0060, "R2 set wins over clear");
    chk("R5 aux irq", {31'h0, irq}, 32'h1);

    wr16(OC, 16'h0100);
    rd16(OC, 16'h0120, "R4 masks follow write");
    chk("R5 no enabled flag", {31'h0, irq}, 32'h0);
    pulse(2);
    rd16(OC, 16'h01A0, "R2 dsp flag set");
    chk("R5 dsp irq", {31'h0, irq}, 32'h1);

    wr16(OC, 16'h0806);
    rd16(OC, 16'h08A6, "R4 control bits stored");
    chk("R4 control outputs", {28'h0, dsp_reset, dsp_assert, dsp_halt, dsp_init},
        32'h7);
    chk("R7 no pad error on clean write", {31'h0, pad_err}, 32'h0);

    aux_busy = 1'b1;
    rd16(OC, 16'h0AA6, "R9 busy bit mirrors input");
    aux_busy = 1'b0;
    wr16(OC, 16'h0A06);
    chk("R9 bit 9 is not padding", {31'h0, pad_err}, 32'h0);
    rd16(OC, 16'h08A6, "R9 write to busy ignored");

    wr16(OC, 16'h1806);
    chk("R7 pad error bit 12", {31'h0, pad_err}, 32'h1);
    @(negedge clk);
    chk("R7 pad error one cycle", {31'h0, pad_err}, 32'h0);
    wr16(OC, 16'h0C06);
    chk("R7 pad error bit 10", {31'h0, pad_err}, 32'h1);
    rd16(OC, 16'h08A6, "R7 padding reads zero");

    wr16(OC, 16'h0807);
    rd16(OA, 16'h0000, "R6 reset bit clears audio dma");
    chk("R6 dsp_reset out", {31'h0, dsp_reset}, 32'h1);

    acc(1'b1, 1'b1, 4'd0, {16'h5555, 16'h0806});
    rd32(4'd0, {16'h5555, 16'h08A6}, "R8 32-bit write and read");
    acc(1'b1, 1'b1, 4'd0, {16'h7777, 16'h0801});
    rd32(4'd0, {16'h0000, 16'h08A1}, "R8 high half first then reset wipes");

    wr16(OC, 16'h00A8);
    rd16(OC, 16'h0000, "R3 all flags cleared");

    repeat (3) @(negedge clk);
    chk("R8 no pending reads", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule